// File: doc/BRIEF.md
# Link Control and Keepalive Scheduler

This block holds the control state for a two-port serial link adapter whose ports are called X and Y. A host writes two 32-bit words through a simple register port. The configuration word carries the self-check enable, its complement and the port-swap control. The port-control word carries transmit and receive reset/enable bits for each port, plus two self-clearing commands: timebase restart and fault clear. Bit 31 of every word is an odd-parity bit. A write whose parity is wrong is dropped and reported.

The self-check enable is stored twice: as a true copy and as an inverted copy. If the two copies ever agree, the block latches a self-check fault. While the fault is set, both physical ports are asked to send the link-bad command symbol and no keepalive is sent. A restart command starts the keepalive timebase. The first keepalive strobe comes a short gap after the restart, and later strobes follow at a fixed long period. Each strobe reaches only the ports whose transmitter is enabled and not held in reset. The swap control can exchange every per-port output between the two physical pins.

Top module: `link_ctl_keepalive`

## Requirements
- R1: A write whose 32 data bits contain an even number of ones leaves both words unchanged. `parity_err` is then high for the one cycle after the write edge. Every word read back has bit 31 set so that the word holds an odd number of ones.
- R2: The configuration word is at address 0, laid out as bit 0 = self-check enable, bit 1 = inverted enable, bit 2 = swap. When bits 0 and 1 are equal (00 or 11), `sc_fault` is high from the second clock edge after the write.
- R3: While `sc_fault` is high, `phy_tlb` is 2'b11 and `phy_ka` is 2'b00, starting from the edge after the fault is set.
- R4: `sc_fault` stays set until the enable pair is consistent and a clear command is written (bit 1 of the port-control word at address 1). A clear written while the pair is still inconsistent has no effect.
- R5: `sc_src_en` follows configuration bit 0 from the edge at which that bit is written.
- R6: Writing bit 0 of the port-control word (restart) raises a keepalive strobe 8 cycles after the write edge. The next strobe follows 512 cycles after that one, and strobes keep coming every 512 cycles.
- R7: A restart written while the timebase is already running discards the old schedule. The next strobe then comes 8 cycles after the new write.
- R8: The per-port fields in the port-control word sit at bits [7:4] for X and [11:8] for Y, ordered {rx_rst, rx_en, tx_rst, tx_en} from high bit to low. A port sends strobes and shows `phy_tx_on` only when tx_en=1 and tx_rst=0; reset wins over enable. `phy_rx_on` follows the same rule for the receive bits.
- R9: With swap set, every per-port output of index 0 (X) is driven from logical port Y's state, and index 1 (Y) from logical port X's. This covers `phy_req` from `req_log`, with one cycle of latency.
- R10: After reset, address 0 reads 0x00000001 and address 1 reads 0x80000000; `sc_fault`, `phy_ka` and `phy_tlb` are all 0.
- R11: The restart and clear command bits are never stored and always read back as 0. Reads are registered: `rd_data` is valid one cycle after `rd_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = configuration word, 1 = port-control word |
| wr_data | input | 32 | Write data, bit 31 odd parity |
| rd_addr | input | 1 | Read address |
| rd_data | output | 32 | Registered read data |
| parity_err | output | 1 | Pulse: last write was rejected for parity |
| sc_fault | output | 1 | Sticky self-check fault |
| sc_src_en | output | 1 | Enable for the link self-check sources |
| req_log | input | 2 | Logical per-port send requests (0 = X, 1 = Y) |
| phy_req | output | 2 | Send requests after swap routing |
| phy_ka | output | 2 | Keepalive symbol strobe per physical port |
| phy_tlb | output | 2 | Link-bad symbol request per physical port |
| phy_tx_on | output | 2 | Transmitter active per physical port |
| phy_rx_on | output | 2 | Receiver active per physical port |

## Verification
The hardest case to reach is the interaction between a running timebase and the fault. A keepalive that is due while the fault holds must disappear on both pins. The same schedule must still be in place for ports that come back later. The stimulus enables port X and starts the timebase after forcing an inconsistent pair. It then waits across two scheduled strobe times while the scoreboard expects nothing, and tries a premature clear before the legal clear sequence. The restart-during-run case is reached by writing a second restart 100 cycles after the first, so that the old 520-cycle slot must stay silent.

// File: rtl/lk_pkg.sv
package lk_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned PAR_BIT = WORD_W - 1;
  localparam int unsigned NPORT   = 2;

  typedef struct packed {
    logic rx_rst;
    logic rx_en;
    logic tx_rst;
    logic tx_en;
  } port_ctl_t;

  function automatic logic odd_fill(input logic [WORD_W-2:0] v);
    return ~(^v);
  endfunction
endpackage

// File: rtl/lk_regs.sv
module lk_regs
  import lk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic                 rd_addr,
  output logic [WORD_W-1:0]    rd_data,
  output logic                 parity_err,
  output logic                 sc_en,
  output logic                 swap,
  output port_ctl_t [NPORT-1:0] port_ctl,
  output logic                 restart,
  output logic                 fault
);
  localparam int unsigned FLD_W = $bits(port_ctl_t);
  localparam int unsigned X_LSB = 4;

  logic sc_en_n;
  logic wr_ok, clr, pair_bad;
  logic [WORD_W-2:0] cfg_body, ctl_body;

  assign wr_ok    = wr_en & (^wr_data);
  assign restart  = wr_ok & wr_addr & wr_data[0];
  assign clr      = wr_ok & wr_addr & wr_data[1];
  assign pair_bad = (sc_en == sc_en_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_en      <= 1'b1;
      sc_en_n    <= 1'b0;
      swap       <= 1'b0;
      port_ctl   <= '0;
      parity_err <= 1'b0;
    end else begin
      parity_err <= wr_en & ~(^wr_data);
      if (wr_ok && !wr_addr) begin
        sc_en   <= wr_data[0];
        sc_en_n <= wr_data[1];
        swap    <= wr_data[2];
      end
      if (wr_ok && wr_addr) begin
        for (int p = 0; p < NPORT; p++)
          port_ctl[p] <= wr_data[X_LSB + p*FLD_W +: FLD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           fault <= 1'b0;
    else if (pair_bad) fault <= 1'b1;
    else if (clr)      fault <= 1'b0;
  end

  assign cfg_body = {{(WORD_W-4){1'b0}}, swap, sc_en_n, sc_en};
  assign ctl_body = {{(WORD_W-1-X_LSB-NPORT*FLD_W){1'b0}}, port_ctl, {X_LSB{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_addr) rd_data <= {odd_fill(ctl_body), ctl_body};
    else              rd_data <= {odd_fill(cfg_body), cfg_body};
  end

  assert_par_reject_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(^wr_data)) |=> (parity_err && $stable(port_ctl) && $stable(swap) && $stable(sc_en)));
  assert_fault_set_R2: assert property (@(posedge clk) disable iff (rst)
    (sc_en == sc_en_n) |=> fault);
  assert_fault_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (fault && !(wr_en && wr_addr && wr_data[1])) |=> fault);
  assert_rd_odd_R1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (^rd_data));
endmodule

// File: rtl/lk_timer.sv
module lk_timer #(
  parameter int unsigned FIRST_GAP = 8,
  parameter int unsigned PERIOD    = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic due
);
  localparam int unsigned MAXV  = (FIRST_GAP > PERIOD) ? FIRST_GAP : PERIOD;
  localparam int unsigned CNT_W = $clog2(MAXV);

  logic             running;
  logic [CNT_W-1:0] cnt;

  assign due = running && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (restart) begin
      running <= 1'b1;
      cnt     <= CNT_W'(FIRST_GAP - 1);
    end else if (running) begin
      if (cnt == '0) cnt <= CNT_W'(PERIOD - 1);
      else           cnt <= cnt - 1'b1;
    end
  end

  assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    restart |=> !due);
  assert_due_single_R6: assert property (@(posedge clk) disable iff (rst)
    (due && !restart) |=> !due);
endmodule

// File: rtl/lk_xbar.sv
module lk_xbar
  import lk_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  swap,
  input  logic                  fault,
  input  logic                  due,
  input  port_ctl_t [NPORT-1:0] port_ctl,
  input  logic [NPORT-1:0]      req_log,
  output logic [NPORT-1:0]      phy_req,
  output logic [NPORT-1:0]      phy_ka,
  output logic [NPORT-1:0]      phy_tlb,
  output logic [NPORT-1:0]      phy_tx_on,
  output logic [NPORT-1:0]      phy_rx_on
);
  for (genvar i = 0; i < NPORT; i++) begin : g_phy
    logic      src;
    port_ctl_t pc;
    logic      tx_ok, rx_ok;

    assign src   = (i == 0) ? swap : ~swap;
    assign pc    = port_ctl[src];
    assign tx_ok = pc.tx_en & ~pc.tx_rst;
    assign rx_ok = pc.rx_en & ~pc.rx_rst;

    always_ff @(posedge clk) begin
      if (rst) begin
        phy_req[i]   <= 1'b0;
        phy_ka[i]    <= 1'b0;
        phy_tlb[i]   <= 1'b0;
        phy_tx_on[i] <= 1'b0;
        phy_rx_on[i] <= 1'b0;
      end else begin
        phy_req[i]   <= req_log[src];
        phy_ka[i]    <= due & tx_ok & ~fault;
        phy_tlb[i]   <= fault;
        phy_tx_on[i] <= tx_ok;
        phy_rx_on[i] <= rx_ok;
      end
    end
  end

  assert_tlb_both_R3: assert property (@(posedge clk) disable iff (rst)
    fault |=> (phy_tlb == '1 && phy_ka == '0));
  assert_swap_route_R9: assert property (@(posedge clk) disable iff (rst)
    swap |=> (phy_req == {$past(req_log[0]), $past(req_log[1])}));
  assert_ka_needs_tx_R8: assert property (@(posedge clk) disable iff (rst)
    (phy_ka & ~phy_tx_on) == '0);
endmodule

// File: rtl/link_ctl_keepalive.sv
module link_ctl_keepalive #(
  parameter int unsigned FIRST_GAP = 8,
  parameter int unsigned KA_PERIOD = 512
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_addr,
  output logic [31:0] rd_data,
  output logic        parity_err,
  output logic        sc_fault,
  output logic        sc_src_en,
  input  logic [1:0]  req_log,
  output logic [1:0]  phy_req,
  output logic [1:0]  phy_ka,
  output logic [1:0]  phy_tlb,
  output logic [1:0]  phy_tx_on,
  output logic [1:0]  phy_rx_on
);
  import lk_pkg::*;

  logic                  swap, restart, due;
  port_ctl_t [NPORT-1:0] port_ctl;

  lk_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .parity_err(parity_err),
    .sc_en(sc_src_en), .swap(swap), .port_ctl(port_ctl),
    .restart(restart), .fault(sc_fault)
  );

  lk_timer #(.FIRST_GAP(FIRST_GAP), .PERIOD(KA_PERIOD)) u_timer (
    .clk(clk), .rst(rst), .restart(restart), .due(due)
  );

  lk_xbar u_xbar (
    .clk(clk), .rst(rst), .swap(swap), .fault(sc_fault), .due(due),
    .port_ctl(port_ctl), .req_log(req_log), .phy_req(phy_req), .phy_ka(phy_ka),
    .phy_tlb(phy_tlb), .phy_tx_on(phy_tx_on), .phy_rx_on(phy_rx_on)
  );
endmodule

// File: tb/tb_link_ctl_keepalive.sv
module tb_link_ctl_keepalive;
  logic        clk = 0, rst = 1;
  logic        wr_en = 0, wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic [1:0]  req_log = 0;
  logic [31:0] rd_data;
  logic        parity_err, sc_fault, sc_src_en;
  logic [1:0]  phy_req, phy_ka, phy_tlb, phy_tx_on, phy_rx_on;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int exp_cyc[$];
  logic [1:0] exp_val[$];
  bit done = 0;

  link_ctl_keepalive dut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mk(input logic [30:0] v);
    return {~(^v), v};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual 0x%08h expected 0x%08h", req, cyc, act, expv);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d, output int w);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    w = cyc;
    wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic push(input int c, input logic [1:0] v);
    exp_cyc.push_back(c);
    exp_val.push_back(v);
  endtask

  // scoreboard monitor: every keepalive strobe must match a queued item (R6, R7, R8)
  always @(negedge clk) begin
    if (!rst) begin
      while (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
        chk(0, "R6 missed keepalive", 32'(phy_ka), 32'(exp_val[0]));
        void'(exp_cyc.pop_front()); void'(exp_val.pop_front());
      end
      if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
        chk(phy_ka == exp_val[0], "R6 keepalive strobe", 32'(phy_ka), 32'(exp_val[0]));
        void'(exp_cyc.pop_front()); void'(exp_val.pop_front());
      end else if (phy_ka != 2'b00) begin
        chk(0, "R7 unexpected keepalive", 32'(phy_ka), 32'h0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int w, w2;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;

    // R10 reset state
    rd(0, d); chk(d == 32'h1, "R10 cfg reset", d, 32'h1);
    rd(1, d); chk(d == 32'h8000_0000, "R10 ctl reset", d, 32'h8000_0000);
    chk(sc_fault == 0 && phy_tlb == 0 && phy_ka == 0, "R10 outputs reset",
        {sc_fault, phy_tlb, phy_ka}, 32'h0);
    chk(sc_src_en == 1, "R5 reset enable", 32'(sc_src_en), 32'h1);

    // R1 bad parity write (swap request with even ones)
    wr(0, 32'h0000_0005, w);
    chk(parity_err == 1, "R1 parity flag", 32'(parity_err), 32'h1);
    rd(0, d); chk(d == 32'h1, "R1 cfg unchanged", d, 32'h1);
    chk(parity_err == 0, "R1 flag is a pulse", 32'(parity_err), 32'h0);

    // R6 enable X tx with restart
    wr(1, mk(31'h11), w);
    push(w + 8, 2'b01); push(w + 520, 2'b01); push(w + 1032, 2'b01);
    rd(1, d); chk(d == 32'h0000_0010, "R11 restart reads 0", d, 32'h10);
    wait_to(w + 1040);
    wr(1, mk(31'h0), w);

    // R7 restart while running, both ports
    wr(1, mk(31'h111), w);
    push(w + 8, 2'b11);
    wait_to(w + 100);
    wr(1, mk(31'h111), w2);
    push(w2 + 8, 2'b11); push(w2 + 520, 2'b11);
    wait_to(w2 + 530);
    wr(1, mk(31'h0), w);

    // R8 reset wins over enable on X
    wr(1, mk(31'h131), w);
    push(w + 8, 2'b10);
    wait_to(w + 1);
    chk(phy_tx_on == 2'b10, "R8 tx_on with X reset", 32'(phy_tx_on), 32'h2);
    wait_to(w + 20);
    wr(1, mk(31'h0), w);

    // R9 swap
    wr(0, mk(31'h5), w);
    rd(0, d); chk(d == 32'h8000_0005, "R1 cfg readback parity", d, 32'h8000_0005);
    wr(1, mk(31'h51), w);
    push(w + 8, 2'b10);
    wait_to(w + 1);
    chk(phy_tx_on == 2'b10, "R9 swapped tx_on", 32'(phy_tx_on), 32'h2);
    chk(phy_rx_on == 2'b10, "R9 swapped rx_on", 32'(phy_rx_on), 32'h2);
    req_log = 2'b01;
    @(negedge clk);
    chk(phy_req == 2'b10, "R9 swapped request", 32'(phy_req), 32'h2);
    req_log = 2'b00;
    wait_to(w + 20);
    wr(1, mk(31'h0), w);
    wr(0, mk(31'h1), w);
    req_log = 2'b10;
    @(negedge clk);
    chk(phy_req == 2'b10, "R9 unswapped request", 32'(phy_req), 32'h2);
    req_log = 2'b00;

    // R2/R3 fault from 11 pair, keepalives suppressed
    wr(0, mk(31'h3), w);
    wait_to(w + 1);
    chk(sc_fault == 1, "R2 fault on 11", 32'(sc_fault), 32'h1);
    wait_to(w + 2);
    chk(phy_tlb == 2'b11, "R3 link-bad both ports", 32'(phy_tlb), 32'h3);
    wr(1, mk(31'h11), w);
    wait_to(w + 530);
    chk(phy_ka == 2'b00, "R3 no keepalive in fault", 32'(phy_ka), 32'h0);
    // R4 premature clear ignored
    wr(1, mk(31'h12), w);
    wait_to(w + 2);
    chk(sc_fault == 1, "R4 clear with bad pair", 32'(sc_fault), 32'h1);
    wr(0, mk(31'h1), w);
    wait_to(w + 2);
    chk(sc_fault == 1, "R4 sticky after fix", 32'(sc_fault), 32'h1);
    wr(1, mk(31'h2), w);
    wait_to(w + 1);
    chk(sc_fault == 0, "R4 cleared", 32'(sc_fault), 32'h0);
    chk(phy_tlb == 2'b00, "R3 link-bad released", 32'(phy_tlb), 32'h0);

    // R5 source enable off, consistent pair
    wr(0, mk(31'h2), w);
    chk(sc_src_en == 0, "R5 source enable off", 32'(sc_src_en), 32'h0);
    wait_to(w + 2);
    chk(sc_fault == 0, "R2 no fault on 01 pair", 32'(sc_fault), 32'h0);
    // R2 pair 00
    wr(0, mk(31'h0), w);
    wait_to(w + 1);
    chk(sc_fault == 1, "R2 fault on 00", 32'(sc_fault), 32'h1);
    wait_to(w + 5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule